// File: doc/BRIEF.md
# Dual Wiper Register Serial Command Slave

This block is the serial front end of a two-channel digital potentiometer controller. It oversamples the two-wire bus lines (SCL, SDA) with the system clock and filters out short glitches. It then recognises bus start and stop conditions and decodes fixed-format command frames that read, write or step one of two 8-bit wiper position registers. SDA is driven only through an open-drain pull-down enable. The current value of each register is presented at the block outputs for the tap-select decoder that sits downstream.

A frame opens with a START and an address byte that has no direction bit. The address byte's upper nibble is the fixed device identifier 0101, and its lower nibble must equal the strap pins. The second byte is an instruction: a 4-bit opcode, three fixed zero bits, and a register select in bit 0. A write frame then carries data bytes. A read frame returns the register contents. In step mode, every later SCL pulse moves the selected wiper one position up or down, according to the SDA level during that pulse.

Top module: `dpot_i2c_slave`

## Requirements
- R1: After reset both wiper outputs equal 0x80 and sda_oe_o is low.
- R2: An address byte equal to {0101, addr_pins_i} (MSB first) is acknowledged by pulling SDA low during the ninth SCL pulse. Any other address byte gets no acknowledge, and the rest of that frame has no effect until the next START.
- R3: The instruction byte is laid out as opcode in bits 7:4, zero in bits 3:1, and register select in bit 0 (0 selects wiper0_o, 1 selects wiper1_o). A valid instruction byte is acknowledged.
- R4: An instruction byte with an opcode other than 1001, 1010 or 0010, or with any of bits 3:1 set, is not acknowledged. The frame then has no effect until STOP or START, and later bytes get no acknowledge.
- R5: Opcode 1010 writes. Each following data byte is acknowledged and loaded into the selected register. The register changes only after the falling SCL edge that ends the acknowledge pulse, so it still holds the old value while SCL is high during that pulse.
- R6: Opcode 1001 reads. The slave shifts out the selected register MSB first, one bit per SCL pulse, then releases SDA. If the master drives a low acknowledge, the value is sent again. If the master does not acknowledge, SDA stays released until STOP or START.
- R7: Opcode 0010 steps. Each later SCL pulse moves the selected register up by one if SDA is high during the pulse, or down by one if SDA is low. The step is applied at the pulse's falling edge. The register saturates at 0x00 and 0xFF, and no acknowledge is driven in this mode.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bytes clocked without a preceding START are ignored. A START in the middle of a frame abandons that frame, so a partly shifted data byte is never written.
- R9: A pulse on SCL or SDA lasting fewer than FILT_CYC system clocks (3 by default) is rejected and does not disturb the frame.
- R10: sda_oe_o changes only while SCL is low, except on a START or STOP. It is low in the cycle after a STOP is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| addr_pins_i | input | 4 | Strap pins matched against the low address nibble |
| wiper0_o | output | 8 | Position register of channel 0 |
| wiper1_o | output | 8 | Position register of channel 1 |

## Verification
The hardest case to reach from the ports is a START that arrives after a write frame has been accepted but before its data byte is complete. If the design goes wrong here, a stale or half-shifted byte could still land in a register. The bench bit-bangs a frame that stops after four data bits, issues a repeated START, and completes a write to the other channel. It then checks that the first channel kept its value. Glitch pulses on both lines are injected into the middle of a written byte. Randomly chosen frames, some with wrong addresses, are checked against a saturating model of both registers.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam logic [3:0] DEV_ID    = 4'b0101;
  localparam logic [3:0] OPC_READ  = 4'b1001;
  localparam logic [3:0] OPC_WRITE = 4'b1010;
  localparam logic [3:0] OPC_STEP  = 4'b0010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INSTR, ST_INSTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RD_MACK, ST_STEP, ST_IGNORE
  } state_e;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE, OP_STEP} op_e;

  function automatic op_e decode_instr(input logic [7:0] b);
    if (b[3:1] != 3'b000) return OP_NONE;
    case (b[7:4])
      OPC_READ:  return OP_READ;
      OPC_WRITE: return OP_WRITE;
      OPC_STEP:  return OP_STEP;
      default:   return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dpot_line_filt.sv
module dpot_line_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      // accept a new level only after FILT_CYC consecutive agreeing samples
      if (sync_q[SYNC_STAGES-1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_CYC - 1)) begin
        filt_q <= sync_q[SYNC_STAGES-1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/dpot_bus_cond.sv
module dpot_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank #(
  parameter int               NUM     = 2,
  parameter int               W       = 8,
  parameter logic [W-1:0]     RST_VAL = W'(1) << (W - 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic                             step_en_i,
  input  logic                             up_i,
  input  logic [(NUM>1?$clog2(NUM):1)-1:0] sel_i,
  input  logic [W-1:0]                     wdata_i,
  output logic [NUM*W-1:0]                 wiper_o
);
  localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1;

  for (genvar ch = 0; ch < NUM; ch++) begin : g_ch
    logic [W-1:0] val_q;
    logic         hit;
    assign hit = (sel_i == SEL_W'(ch));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= RST_VAL;
      end else if (hit && wr_en_i) begin
        val_q <= wdata_i;
      end else if (hit && step_en_i) begin
        if (up_i && val_q != '1)       val_q <= val_q + 1'b1;
        else if (!up_i && val_q != '0) val_q <= val_q - 1'b1;
      end
    end

    assign wiper_o[ch*W +: W] = val_q;
  end
endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave
  import dpot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [3:0] addr_pins_i,
  output logic [7:0] wiper0_o,
  output logic [7:0] wiper1_o
);
  localparam int NUM_WIPERS = 2;
  localparam int WIPER_W    = 8;

  logic [1:0] raw_lines, filt_lines;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    dpot_line_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  dpot_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  state_e     state_q;
  op_e        op_q, op_dec;
  logic [2:0] cnt_q;
  logic [7:0] shreg_q;
  logic       full_q, sel_q, dir_q, armed_q, mack_q;
  logic       wr_en, step_en;
  logic [NUM_WIPERS*WIPER_W-1:0] wip_flat;
  logic [7:0] rd_val;

  assign op_dec = decode_instr(shreg_q);
  assign rd_val = sel_q ? wip_flat[15:8] : wip_flat[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      cnt_q   <= '0;
      shreg_q <= '0;
      full_q  <= 1'b0;
      sel_q   <= 1'b0;
      dir_q   <= 1'b0;
      armed_q <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      full_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_INSTR, ST_WDATA: begin
          if (scl_rise) begin
            shreg_q <= {shreg_q[6:0], sda_f};
            cnt_q   <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) full_q <= 1'b1;
          end else if (scl_fall && full_q) begin
            full_q <= 1'b0;
            if (state_q == ST_ADDR) begin
              state_q <= (shreg_q == {DEV_ID, addr_pins_i}) ? ST_ADDR_ACK : ST_IGNORE;
            end else if (state_q == ST_INSTR) begin
              op_q    <= op_dec;
              sel_q   <= shreg_q[0];
              state_q <= (op_dec == OP_NONE) ? ST_IGNORE : ST_INSTR_ACK;
            end else begin
              state_q <= ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          state_q <= ST_INSTR;
          cnt_q   <= '0;
        end
        ST_INSTR_ACK: if (scl_fall) begin
          cnt_q <= '0;
          case (op_q)
            OP_READ: begin
              state_q <= ST_RDATA;
              shreg_q <= rd_val;
            end
            OP_WRITE: state_q <= ST_WDATA;
            default:  state_q <= ST_STEP;
          endcase
        end
        ST_WDATA_ACK: if (scl_fall) begin
          state_q <= ST_WDATA;
          cnt_q   <= '0;
        end
        ST_RDATA: if (scl_fall) begin
          if (cnt_q == 3'd7) begin
            state_q <= ST_RD_MACK;
            cnt_q   <= '0;
          end else begin
            shreg_q <= {shreg_q[6:0], 1'b0};
            cnt_q   <= cnt_q + 3'd1;
          end
        end
        ST_RD_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_f;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_q <= ST_RDATA;
              shreg_q <= rd_val;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        ST_STEP: begin
          // direction latched while SCL high, applied on the falling edge so a STOP pulse never steps
          if (scl_rise) begin
            dir_q   <= sda_f;
            armed_q <= 1'b1;
          end else if (scl_fall) begin
            armed_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en   = (state_q == ST_WDATA_ACK) && scl_fall;
  assign step_en = (state_q == ST_STEP) && scl_fall && armed_q;

  assign sda_oe_o = (state_q == ST_ADDR_ACK) || (state_q == ST_INSTR_ACK) ||
                    (state_q == ST_WDATA_ACK) || ((state_q == ST_RDATA) && !shreg_q[7]);

  dpot_wiper_bank #(.NUM(NUM_WIPERS), .W(WIPER_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .step_en_i(step_en),
    .up_i     (dir_q),
    .sel_i    (sel_q),
    .wdata_i  (shreg_q),
    .wiper_o  (wip_flat)
  );

  assign wiper0_o = wip_flat[7:0];
  assign wiper1_o = wip_flat[15:8];
endmodule

// File: rtl/dpot_i2c_slave_chk.sv
module dpot_i2c_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_i,
  input logic       scl_f_i,
  input logic       start_i,
  input logic       stop_i,
  input logic       wr_en_i,
  input logic       step_en_i,
  input logic [7:0] wiper0_i,
  input logic [7:0] wiper1_i
);
  // R10
  oe_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_f_i && $past(scl_f_i) && !$past(start_i || stop_i) |-> $stable(sda_oe_i));

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  // R5
  wr_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !scl_f_i);

  // R7
  step_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_i, step_en_i}));

  // R7
  step0_unit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (wiper0_i == $past(wiper0_i)) || (wiper0_i == $past(wiper0_i) + 8'd1) ||
                 (wiper0_i == $past(wiper0_i) - 8'd1));

  // R7
  step1_unit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (wiper1_i == $past(wiper1_i)) || (wiper1_i == $past(wiper1_i) + 8'd1) ||
                 (wiper1_i == $past(wiper1_i) - 8'd1));
endmodule

bind dpot_i2c_slave dpot_i2c_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sda_oe_i (sda_oe_o),
  .scl_f_i  (scl_f),
  .start_i  (start_det),
  .stop_i   (stop_det),
  .wr_en_i  (wr_en),
  .step_en_i(step_en),
  .wiper0_i (wiper0_o),
  .wiper1_i (wiper1_o)
);

// File: tb/tb_dpot_i2c_slave.sv
module tb_dpot_i2c_slave;
  localparam int HALF = 16;
  localparam logic [3:0] PINS = 4'b0110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] w0, w1;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  logic [7:0] mdl [2];
  logic [15:0] wip_at_ack;

  always #4 clk = ~clk;

  dpot_i2c_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_pins_i(PINS), .wiper0_o(w0), .wiper1_o(w1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp(input int n = HALF);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] instr(input logic [3:0] opc, input bit sel);
    return {opc, 3'b000, sel};
  endfunction

  function automatic logic [7:0] sat_step(input logic [7:0] v, input bit up);
    if (up) return (v == 8'hFF) ? v : v + 8'd1;
    return (v == 8'h00) ? v : v - 8'd1;
  endfunction

  task automatic start_c();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp();
      if (glitch && i == 4) begin
        scl_m = 1'b1; hp(2); scl_m = 1'b0; hp();
      end
      scl_m = 1'b1;
      if (glitch && i == 2) begin
        hp(HALF/2); sda_m = ~b[i]; hp(2); sda_m = b[i]; hp(HALF/2);
      end else hp();
      scl_m = 1'b0; hp();
    end
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(HALF/2);
    ack = ~sda_bus;
    wip_at_ack = {w1, w0};
    hp(HALF/2); scl_m = 1'b0; hp();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hp(); scl_m = 1'b1; hp(HALF/2);
      b[i] = sda_bus;
      hp(HALF/2); scl_m = 1'b0; hp();
    end
    sda_m = ~mack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp(); sda_m = 1'b1;
  endtask

  task automatic step_pulse(input bit up, output bit oe_seen);
    sda_m = up; hp(); scl_m = 1'b1; hp(HALF/2);
    oe_seen = sda_oe;
    hp(HALF/2); scl_m = 1'b0; hp();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
    $finish;
  end

  initial begin
    bit a0, a1, a2, oe;
    logic [7:0] rb, gaddr, badaddr, d;
    gaddr = {4'b0101, PINS};
    mdl[0] = 8'h80; mdl[1] = 8'h80;
    hp(5); rst_n = 1'b1; hp(5);

    // R1 reset state
    chk(w0 == 8'h80, "R1 wiper0", w0, 8'h80);
    chk(w1 == 8'h80, "R1 wiper1", w1, 8'h80);
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);

    // R2 R3 R5 write channel 0, value held during ack clock
    start_c();
    send_byte(gaddr, 0, a0); send_byte(instr(4'b1010, 0), 0, a1); send_byte(8'h3C, 0, a2);
    chk(wip_at_ack[7:0] == 8'h80, "R5 old value during ack", wip_at_ack[7:0], 8'h80);
    send_byte(8'h3D, 0, oe);
    stop_c(); mdl[0] = 8'h3D;
    chk(a0, "R2 address ack", a0, 1);
    chk(a1, "R3 instruction ack", a1, 1);
    chk(a2 && oe, "R5 data acks", {a2, oe}, 2'b11);
    chk(w0 == 8'h3D, "R5 second data byte written", w0, 8'h3D);

    // R6 read with master ack then nack
    start_c();
    send_byte(gaddr, 0, a0); send_byte(instr(4'b1001, 0), 0, a1);
    recv_byte(1, rb);
    chk(rb == 8'h3D, "R6 first read byte", rb, 8'h3D);
    recv_byte(0, rb);
    chk(rb == 8'h3D, "R6 repeated after master ack", rb, 8'h3D);
    recv_byte(0, rb);
    chk(rb == 8'hFF, "R6 released after nack", rb, 8'hFF);
    stop_c();

    // R2 wrong address: whole frame ignored
    start_c();
    send_byte({4'b0101, PINS ^ 4'b0001}, 0, a0);
    send_byte(instr(4'b1010, 1), 0, a1); send_byte(8'h11, 0, a2);
    stop_c();
    chk(!a0 && !a1 && !a2, "R2 mismatch no acks", {a0, a1, a2}, 0);
    chk(w1 == 8'h80, "R2 mismatch no write", w1, 8'h80);
    start_c(); send_byte(8'h36, 0, a0); stop_c();
    chk(!a0, "R2 wrong identifier", a0, 0);

    // R4 undefined opcode and nonzero fixed bits
    start_c();
    send_byte(gaddr, 0, a0); send_byte(8'hB1, 0, a1); send_byte(8'h22, 0, a2);
    stop_c();
    chk(!a1 && !a2, "R4 bad opcode no ack", {a1, a2}, 0);
    chk(w1 == 8'h80, "R4 bad opcode no write", w1, 8'h80);
    start_c();
    send_byte(gaddr, 0, a0); send_byte(8'hA3, 0, a1); send_byte(8'h22, 0, a2);
    stop_c();
    chk(!a1 && !a2 && w1 == 8'h80, "R4 fixed bits nonzero", {a1, a2, w1}, 8'h80);

    // R7 step channel 1: +3 -1
    start_c();
    send_byte(gaddr, 0, a0); send_byte(instr(4'b0010, 1), 0, a1);
    oe = 1'b0;
    for (int k = 0; k < 4; k++) begin
      bit o;
      step_pulse(k != 3, o); oe |= o;
    end
    stop_c(); mdl[1] = 8'h82;
    chk(a1, "R7 instruction ack", a1, 1);
    chk(!oe, "R7 no ack while stepping", oe, 0);
    chk(w1 == 8'h82, "R7 step result", w1, 8'h82);

    // R7 saturation at both ends
    start_c(); send_byte(gaddr, 0, a0); send_byte(instr(4'b1010, 0), 0, a0);
    send_byte(8'hFF, 0, a0); stop_c();
    start_c(); send_byte(gaddr, 0, a0); send_byte(instr(4'b0010, 0), 0, a0);
    step_pulse(1, oe); step_pulse(1, oe); stop_c();
    chk(w0 == 8'hFF, "R7 saturate high", w0, 8'hFF);
    start_c(); send_byte(gaddr, 0, a0); send_byte(instr(4'b1010, 0), 0, a0);
    send_byte(8'h01, 0, a0); stop_c();
    start_c(); send_byte(gaddr, 0, a0); send_byte(instr(4'b0010, 0), 0, a0);
    step_pulse(0, oe); step_pulse(0, oe); step_pulse(0, oe); stop_c();
    chk(w0 == 8'h00, "R7 saturate low", w0, 8'h00);
    mdl[0] = 8'h00;

    // R8 repeated START mid data byte aborts it
    start_c();
    send_byte(gaddr, 0, a0); send_byte(instr(4'b1010, 0), 0, a0);
    put_bit(1); put_bit(0); put_bit(1); put_bit(0);
    start_c();
    send_byte(gaddr, 0, a0); send_byte(instr(4'b1010, 1), 0, a1); send_byte(8'h5A, 0, a2);
    stop_c(); mdl[1] = 8'h5A;
    chk(w0 == 8'h00, "R8 aborted write kept old", w0, 8'h00);
    chk(w1 == 8'h5A && a2, "R8 frame after repeated start", w1, 8'h5A);
    // R8 no START: bytes ignored
    send_byte(gaddr, 0, a0);
    chk(!a0, "R8 ignored without start", a0, 0);
    stop_c();

    // R9 glitches on both lines during a written byte
    start_c();
    send_byte(gaddr, 0, a0); send_byte(instr(4'b1010, 0), 0, a1); send_byte(8'h96, 1, a2);
    stop_c(); mdl[0] = 8'h96;
    chk(w0 == 8'h96 && a2, "R9 glitch rejected", w0, 8'h96);

    // random frames, fixed seed
    void'($urandom(32'h5EED));
    for (int it = 0; it < 24; it++) begin
      int op; bit sel, good;
      op = $urandom_range(0, 2);
      sel = 1'($urandom_range(0, 1));
      good = ($urandom_range(0, 7) != 0);
      d = 8'($urandom);
      badaddr = {4'b0101, PINS ^ 4'($urandom_range(1, 15))};
      start_c();
      send_byte(good ? gaddr : badaddr, 0, a0);
      chk(a0 == good, "R2 random address ack", a0, good);
      if (op == 0) begin
        send_byte(instr(4'b1010, sel), 0, a1); send_byte(d, 0, a2); stop_c();
        if (good) mdl[sel] = d;
      end else if (op == 1) begin
        send_byte(instr(4'b1001, sel), 0, a1); recv_byte(0, rb); stop_c();
        chk(rb == (good ? mdl[sel] : 8'hFF), "R6 random read", rb, good ? mdl[sel] : 8'hFF);
      end else begin
        int n;
        n = $urandom_range(1, 6);
        send_byte(instr(4'b0010, sel), 0, a1);
        for (int k = 0; k < n; k++) begin
          bit up;
          up = 1'($urandom_range(0, 1));
          step_pulse(up, oe);
          if (good) mdl[sel] = sat_step(mdl[sel], up);
        end
        stop_c();
      end
      chk(w0 == mdl[0] && w1 == mdl[1], "R5 R7 random wiper model", {w1, w0}, {mdl[1], mdl[0]});
    end

    summary();
    $finish;
  end
endmodule